// File: doc/BRIEF.md
# Fixed-Frame Packet Depadder

This block undoes fixed-size framing on a 64-bit valid/ready word stream. The input has no end-of-packet marker. Packets arrive in frames that always hold the same number of words, so the block finds each frame boundary by counting accepted words up to a programmed frame size. The first word of every frame is the packet header. Its byte-length field tells the block how many of the frame's words belong to the packet. Those words go to the output unchanged, and the last of them is marked with `out_last`. Every remaining word of the frame is filler: the block accepts it from the input and drops it.

The frame size is sampled from `frame_words` during reset and again on each one-cycle synchronous `clr`. When a header declares more words than the frame holds, the block raises a sticky `err`. It then consumes and drops that whole frame, so word alignment for the following frames is kept. The data path adds no latency. Output valid, output data and input ready are combinational functions of the input word and the current frame position.

Top module: `frame_depad`

## Requirements
- R1: During reset or a cycle with `clr` high, the frame size is loaded from `frame_words`, the frame position returns to the header slot and `err` is cleared. In a `clr` cycle, `in_ready` and `out_valid` are both low.
- R2: The header is the first word of a frame. Its bits [31:16] hold the packet length in bytes. The packet occupies ceil(length/8) words, and a length of 0 counts as one word.
- R3: Packet words are forwarded with `out_data` equal to `in_data` and `out_valid` equal to `in_valid`. `out_last` is high only on the final packet word.
- R4: Filler words, meaning those after the packet inside a frame, are accepted with `in_ready` high whatever `out_ready` is. For those words `out_valid` stays low.
- R5: While a packet word is presented, `in_ready` equals `out_ready`, so no word is lost under backpressure.
- R6: A new frame header is expected after every `frame_words` accepted words, and frames follow each other with no idle cycles needed. Frame size 8 with lengths 8, 16, 24 and 32 gives 10 output words from 32 input words.
- R7: If the header's word count exceeds the frame size, `err` rises after that header is accepted. No word of that frame is output, and all of its words are still consumed.
- R8: Once `err` is set it stays high until `clr` or reset.
- R9: With a frame size of 1, every word is a frame and is forwarded with `out_last`. A `frame_words` value of 0 is treated as 1.
- R10: A packet that fills its frame exactly is forwarded whole, with no filler and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | One-cycle synchronous clear that also loads the frame size |
| frame_words | input | 16 | Frame size in 64-bit words, sampled on reset or clear |
| in_data | input | 64 | Input word |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| out_data | output | 64 | Forwarded packet word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream ready |
| out_last | output | 1 | Marks the final word of a packet |
| err | output | 1 | Sticky flag for an oversized packet |

## Verification
The bench targets lengths that sit next to word and frame edges: 0 bytes, lengths one byte under and over a multiple of 8, an exact-fit packet, and a packet one word too long. A design that rounds the length down would cut off the last word or misplace `out_last`. A design with an off-by-one in the size comparison would either flag the exact-fit frame or forward the oversized one. The bench drops `out_ready` during filler to catch a design that stalls on words it discards. It also drops `out_ready` during packet words to catch a design that accepts words it cannot pass on. A design that miscounts the frame would take a filler word as the next header and corrupt every later frame. The bench detects this through the per-frame and back-to-back output counts, and through frame size 1.

// File: rtl/fdp_pkg.sv
package fdp_pkg;
  localparam int unsigned FDP_LEN_W  = 16;
  localparam int unsigned FDP_CNT_W  = 16;
  localparam int unsigned FDP_BYTE_SH = 3;

  // Packet words from a byte length, rounded up, never below one.
  function automatic logic [FDP_CNT_W-1:0] len_to_words(input logic [FDP_LEN_W-1:0] len);
    logic [FDP_LEN_W:0] padded;
    padded = {1'b0, len} + ((FDP_LEN_W+1)'(1) << FDP_BYTE_SH) - (FDP_LEN_W+1)'(1);
    if (len == '0) return FDP_CNT_W'(1);
    return FDP_CNT_W'(padded >> FDP_BYTE_SH);
  endfunction

  // A programmed size of zero behaves as one word per frame.
  function automatic logic [FDP_CNT_W-1:0] eff_size(input logic [FDP_CNT_W-1:0] sz);
    return (sz == '0) ? FDP_CNT_W'(1) : sz;
  endfunction

  function automatic logic too_long(input logic [FDP_CNT_W-1:0] words,
                                    input logic [FDP_CNT_W-1:0] size);
    return words > size;
  endfunction
endpackage

// File: rtl/fdp_frame_pos.sv
module fdp_frame_pos
  import fdp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic [FDP_CNT_W-1:0] size_in,
  input  logic                 accept,
  output logic [FDP_CNT_W-1:0] fsize,
  output logic                 at_hdr,
  output logic                 frame_end
);
  logic [FDP_CNT_W-1:0] pos_q;
  logic [FDP_CNT_W-1:0] size_q;

  assign fsize     = size_q;
  assign at_hdr    = (pos_q == '0);
  assign frame_end = accept && (pos_q == size_q - FDP_CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      size_q <= eff_size(size_in);
      pos_q  <= '0;
    end else if (accept) begin
      pos_q <= frame_end ? '0 : pos_q + FDP_CNT_W'(1);
    end
  end
endmodule

// File: rtl/fdp_hdr_decode.sv
module fdp_hdr_decode
  import fdp_pkg::*;
(
  input  logic [FDP_LEN_W-1:0] len_field,
  input  logic [FDP_CNT_W-1:0] fsize,
  output logic [FDP_CNT_W-1:0] hdr_words,
  output logic                 oversize
);
  always_comb begin
    hdr_words = len_to_words(len_field);
    oversize  = too_long(hdr_words, fsize);
  end
endmodule

// File: rtl/fdp_pkt_track.sv
module fdp_pkt_track
  import fdp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 accept,
  input  logic                 at_hdr,
  input  logic [FDP_CNT_W-1:0] hdr_words,
  input  logic                 oversize,
  output logic [FDP_CNT_W-1:0] left,
  output logic                 err
);
  logic [FDP_CNT_W-1:0] left_q;
  logic                 err_q;

  assign left = left_q;
  assign err  = err_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      left_q <= '0;
      err_q  <= 1'b0;
    end else if (accept) begin
      if (at_hdr) begin
        left_q <= oversize ? '0 : hdr_words - FDP_CNT_W'(1);
        if (oversize) err_q <= 1'b1;
      end else if (left_q != '0) begin
        left_q <= left_q - FDP_CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/frame_depad.sv
module frame_depad
  import fdp_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned LEN_LSB = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic [FDP_CNT_W-1:0] frame_words,
  input  logic [DATA_W-1:0]    in_data,
  input  logic                 in_valid,
  output logic                 in_ready,
  output logic [DATA_W-1:0]    out_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 out_last,
  output logic                 err
);
  logic [FDP_CNT_W-1:0] fsize;
  logic [FDP_CNT_W-1:0] hdr_words;
  logic [FDP_CNT_W-1:0] left;
  logic                 ev_hdr;
  logic                 ev_accept;
  logic                 ev_frame_end;
  logic                 ev_oversize;
  logic                 ev_fwd;
  logic                 ev_final;

  fdp_frame_pos u_pos (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .size_in   (frame_words),
    .accept    (ev_accept),
    .fsize     (fsize),
    .at_hdr    (ev_hdr),
    .frame_end (ev_frame_end)
  );

  fdp_hdr_decode u_dec (
    .len_field (in_data[LEN_LSB +: FDP_LEN_W]),
    .fsize     (fsize),
    .hdr_words (hdr_words),
    .oversize  (ev_oversize)
  );

  fdp_pkt_track u_trk (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .accept    (ev_accept),
    .at_hdr    (ev_hdr),
    .hdr_words (hdr_words),
    .oversize  (ev_oversize),
    .left      (left),
    .err       (err)
  );

  always_comb begin
    ev_fwd    = ev_hdr ? !ev_oversize : (left != '0);
    ev_final  = ev_hdr ? (hdr_words == FDP_CNT_W'(1)) : (left == FDP_CNT_W'(1));
    in_ready  = !clr && (ev_fwd ? out_ready : 1'b1);
    out_valid = !clr && in_valid && ev_fwd;
    out_last  = out_valid && ev_final;
    out_data  = in_data;
    ev_accept = in_valid && in_ready;
  end
endmodule

// File: rtl/fdp_checker.sv
module fdp_checker #(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              clr,
  input logic [DATA_W-1:0] in_data,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_last,
  input logic              err,
  input logic              ev_hdr,
  input logic              ev_oversize,
  input logic              ev_accept
);
  p_clr_block_r1: assert property (@(posedge clk) disable iff (rst)
    clr |-> (!in_ready && !out_valid));
  p_pass_data_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (in_valid && out_data == in_data));
  p_last_valid_r3: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);
  p_filler_ready_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !out_valid && !clr) |-> in_ready);
  p_no_loss_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);
  p_oversize_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (ev_accept && ev_hdr && ev_oversize) |=> err);
  p_oversize_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (ev_hdr && ev_oversize) |-> !out_valid);
  p_err_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (err && !clr) |=> err);
  p_err_clear_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> !err);
endmodule

bind frame_depad fdp_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .clr         (clr),
  .in_data     (in_data),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_data    (out_data),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_last    (out_last),
  .err         (err),
  .ev_hdr      (ev_hdr),
  .ev_oversize (ev_oversize),
  .ev_accept   (ev_accept)
);

// File: tb/sim_frame_depad.sv
`timescale 1ns/1ps
module sim_frame_depad;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr = 1'b0;
  logic [15:0] frame_words = 16'd8;
  logic [63:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] out_data;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_last;
  logic        err;

  int checks = 0;
  int errors = 0;
  int out_cnt = 0;
  int cyc = 0;
  int cur_size = 8;

  always #4 clk = ~clk;

  frame_depad u0 (
    .clk(clk), .rst(rst), .clr(clr), .frame_words(frame_words),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_last(out_last), .err(err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (out_valid && out_ready) out_cnt <= out_cnt + 1;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int words_of(input int len);
    int w;
    w = len / 8;
    if (len % 8 != 0) w = w + 1;
    if (w == 0) w = 1;
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ready_mode: 0 random, 1 always high, 2 low during filler words
  task automatic send_frame(input int len, input int ready_mode);
    int n;
    bit bad;
    int idx;
    logic [63:0] w;
    bit fwd;
    n = words_of(len);
    bad = (n > cur_size);
    idx = 0;
    w = {32'($urandom), 16'(len), 16'($urandom)};
    while (idx < cur_size) begin
      @(negedge clk);
      in_data  = w;
      in_valid = ($urandom % 4) != 0;
      fwd = !bad && (idx < n);
      case (ready_mode)
        1: out_ready = 1'b1;
        2: out_ready = fwd ? 1'b1 : 1'b0;
        default: out_ready = ($urandom % 3) != 0;
      endcase
      #1;
      if (fwd) begin
        chk(in_ready == out_ready, "R5 ready follows downstream", in_ready, out_ready);
        chk(out_valid == in_valid, "R3 packet word valid", out_valid, in_valid);
        if (out_valid) begin
          chk(out_data == in_data, "R3 data passthrough", out_data, in_data);
          chk(out_last == (idx == n - 1), (idx == 0) ? "R2 header word count" : "R3 last marker",
              out_last, (idx == n - 1));
        end
      end else begin
        chk(in_ready == 1'b1, bad ? "R7 oversize frame consumed" : "R4 filler ready", in_ready, 1);
        chk(out_valid == 1'b0, bad ? "R7 oversize frame dropped" : "R4 filler dropped", out_valid, 0);
      end
      if (in_valid && in_ready) begin
        idx = idx + 1;
        w = {32'($urandom), 32'($urandom)};
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
  endtask

  task automatic do_clear(input int sz);
    @(negedge clk);
    clr = 1'b1;
    frame_words = 16'(sz);
    in_valid = 1'b1;
    in_data = 64'h0000_0000_0008_0000;
    #1;
    chk(in_ready == 1'b0 && out_valid == 1'b0, "R1 clear blocks handshake",
        {in_ready, out_valid}, 0);
    @(negedge clk);
    clr = 1'b0;
    in_valid = 1'b0;
    #1;
    chk(err == 1'b0, "R8 clear drops error", err, 0);
    cur_size = (sz == 0) ? 1 : sz;
  endtask

  initial begin
    int base;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(err == 1'b0, "R1 reset error low", err, 0);
    chk(out_valid == 1'b0 && out_last == 1'b0, "R1 reset output idle", {out_valid, out_last}, 0);

    // frame of 8, length 32 -> 4 words
    base = out_cnt;
    send_frame(32, 1);
    chk(out_cnt - base == 4, "R3 length 32 word count", out_cnt - base, 4);

    // back-to-back frames 8/16/24/32 bytes -> 10 words
    base = out_cnt;
    send_frame(8, 0);
    send_frame(16, 0);
    send_frame(24, 2);
    send_frame(32, 0);
    chk(out_cnt - base == 10, "R6 back-to-back output count", out_cnt - base, 10);

    // lengths near word edges
    base = out_cnt;
    send_frame(0, 0);
    send_frame(9, 2);
    send_frame(15, 0);
    send_frame(17, 0);
    chk(out_cnt - base == 1 + 2 + 2 + 3, "R2 rounding up", out_cnt - base, 8);

    // exact fit
    base = out_cnt;
    send_frame(64, 0);
    chk(out_cnt - base == 8, "R10 exact fit count", out_cnt - base, 8);
    chk(err == 1'b0, "R10 exact fit no error", err, 0);

    // one word too long
    base = out_cnt;
    send_frame(65, 2);
    chk(out_cnt - base == 0, "R7 oversize nothing output", out_cnt - base, 0);
    chk(err == 1'b1, "R7 error raised", err, 1);
    send_frame(16, 0);
    chk(err == 1'b1, "R8 error sticky", err, 1);
    do_clear(10);

    // frame size 1
    do_clear(1);
    base = out_cnt;
    send_frame(8, 0);
    send_frame(3, 0);
    send_frame(0, 1);
    chk(out_cnt - base == 3, "R9 single-word frames", out_cnt - base, 3);
    do_clear(0);
    base = out_cnt;
    send_frame(5, 1);
    send_frame(8, 0);
    chk(out_cnt - base == 2, "R9 size zero as one", out_cnt - base, 2);

    // random frames
    for (int f = 0; f < 60; f++) begin
      int sz;
      int len;
      int n;
      if (f % 6 == 0) do_clear(1 + ($urandom % 12));
      sz = cur_size;
      len = $urandom % (sz * 8 + 17);
      n = words_of(len);
      base = out_cnt;
      send_frame(len, $urandom % 3);
      chk(out_cnt - base == ((n > sz) ? 0 : n), "R6 random frame output count",
          out_cnt - base, (n > sz) ? 0 : n);
      if (n > sz) begin
        chk(err == 1'b1, "R7 random oversize error", err, 1);
        do_clear(sz);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule